// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the sequence of column addresses for one burst access to a DRAM array. When the access sequencer starts an access it presents the starting column address, a per-access burst request, a burst-length code and a no-wrap level. The block captures all of these on the start strobe. It then steps the column address once for every beat-advance strobe the sequencer issues. When the programmed number of beats has gone out, it raises a done flag. The first beat, at the captured address, counts as one of these beats.

The address can step in two ways. In wrap mode only the low bits that index within an aligned block of the burst length change, and they roll over inside that block. In linear mode, selected when the no-wrap input is high, the whole column address counts up by one and carries into the upper bits. Bursting is only possible while the controller is set to latch incoming addresses. Without that setting, or without a burst request, the start strobe only captures the address.

Top module: `burst_col_gen`

## Requirements
- R1: While rst_ni is low, col_addr_o is 0, burst_active_o is 0 and burst_done_o is 0.
- R2: A clock edge with start_i high loads col_addr_i into col_addr_o, whatever the other inputs are.
- R3: burst_active_o goes high after a start only when burst_req_i and latch_mode_i are both 1 at that edge. Otherwise it stays low, beat_i has no effect on col_addr_o and burst_done_o stays 0.
- R4: blen_sel_i selects the burst length: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16 beats.
- R5: In wrap mode (no-wrap latched as 0), each accepted beat adds one to the low log2(length) bits of col_addr_o modulo the length and leaves the upper bits unchanged.
- R6: In linear mode (no_wrap_i latched as 1, logic 1 meaning asserted), each accepted beat adds one to the full col_addr_o, carrying into the upper bits and rolling over from all ones to zero.
- R7: burst_done_o goes high on the edge that issues the length-th beat, counting the start address as the first beat, which is length-1 accepted beats after start. It stays high until the next start.
- R8: Beat strobes that arrive while burst_done_o is high leave col_addr_o unchanged.
- R9: An edge with neither start_i nor beat_i high leaves col_addr_o unchanged.
- R10: When start_i and beat_i are high at the same edge, the start wins. The new address is loaded without a step, and the beat count begins again.
- R11: The burst length and no-wrap mode are sampled at start. Changing blen_sel_i or no_wrap_i during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| latch_mode_i | input | 1 | Controller is in address-latch configuration; required for bursting |
| start_i | input | 1 | Access start strobe; captures address and burst settings |
| col_addr_i | input | COL_W | Starting column address |
| burst_req_i | input | 1 | Burst requested for this access |
| blen_sel_i | input | 2 | Burst length code (0:2, 1:4, 2:8, 3:16) |
| no_wrap_i | input | 1 | 1 selects linear incrementing, 0 selects wrap within the aligned block |
| beat_i | input | 1 | Beat-advance strobe from the access sequencer |
| col_addr_o | output | COL_W | Current column address |
| burst_active_o | output | 1 | A burst was accepted at the last start |
| burst_done_o | output | 1 | All beats of the burst have been issued |

## Verification
The bench runs every start address under every length and both modes. This catches a wrap mask of the wrong width, which would change or fail to change the wrong bit, and a linear step that loses its carry at the top of the address. The done flag is compared beat by beat, so a counter that leaves out the first beat or skips the cap will show up as done one beat late or as an address that still moves after the end. Further tests cover a start that collides with a beat, settings changed in the middle of a burst, idle gaps between beats, and starts made without a burst request or without latch configuration. A design that let the beat win, read settings live or stepped while inactive would give a wrong address.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int unsigned MAX_LEN_LOG2 = 4;
  localparam int unsigned CNT_W = MAX_LEN_LOG2 + 1;

  typedef enum logic [1:0] {
    BL_2  = 2'd0,
    BL_4  = 2'd1,
    BL_8  = 2'd2,
    BL_16 = 2'd3
  } blen_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_pkg::*;
(
  input  blen_e                   sel_i,
  output logic [MAX_LEN_LOG2-1:0] mask_o,
  output logic [CNT_W-1:0]        len_o
);
  // bit i of the mask is set when the block spans at least 2^(i+1) locations
  for (genvar i = 0; i < MAX_LEN_LOG2; i++) begin : g_mask
    assign mask_o[i] = (i <= int'(sel_i));
  end

  assign len_o = {1'b0, mask_o} + CNT_W'(1);
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 12
) (
  input  logic [COL_W-1:0]        col_i,
  input  logic [MAX_LEN_LOG2-1:0] mask_i,
  input  logic                    no_wrap_i,
  output logic [COL_W-1:0]        wmask_o,
  output logic [COL_W-1:0]        next_o
);
  localparam int unsigned PAD_W = COL_W - MAX_LEN_LOG2;

  logic [COL_W-1:0] incr;

  assign wmask_o = {{PAD_W{1'b0}}, mask_i};
  assign incr    = col_i + COL_W'(1);

  always_comb begin
    if (no_wrap_i) next_o = incr;
    else           next_o = (col_i & ~wmask_o) | (incr & wmask_o);
  end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_col_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             en_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             active_o,
  output logic             done_o,
  output logic             step_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  assign active_o = act_q;
  assign done_o   = act_q & (cnt_q == len_i);
  assign step_o   = act_q & adv_i & ~load_i & ~done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      act_q <= en_i;
      cnt_q <= CNT_W'(1); // start address is beat one
    end else if (step_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latch_mode_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_addr_i,
  input  logic             burst_req_i,
  input  logic [1:0]       blen_sel_i,
  input  logic             no_wrap_i,
  input  logic             beat_i,
  output logic [COL_W-1:0] col_addr_o,
  output logic             burst_active_o,
  output logic             burst_done_o
);
  logic [COL_W-1:0]        col_q;
  blen_e                   blen_q;
  logic                    nw_q;
  logic [MAX_LEN_LOG2-1:0] mask;
  logic [CNT_W-1:0]        len;
  logic [COL_W-1:0]        wmask;
  logic [COL_W-1:0]        col_next;
  logic                    step;

  burst_len_decode u_dec (
    .sel_i  (blen_q),
    .mask_o (mask),
    .len_o  (len)
  );

  burst_addr_step #(.COL_W(COL_W)) u_step (
    .col_i     (col_q),
    .mask_i    (mask),
    .no_wrap_i (nw_q),
    .wmask_o   (wmask),
    .next_o    (col_next)
  );

  burst_beat_counter u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_i),
    .en_i     (burst_req_i & latch_mode_i),
    .adv_i    (beat_i),
    .len_i    (len),
    .active_o (burst_active_o),
    .done_o   (burst_done_o),
    .step_o   (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      blen_q <= BL_2;
      nw_q   <= 1'b0;
    end else if (start_i) begin
      col_q  <= col_addr_i;
      blen_q <= blen_e'(blen_sel_i);
      nw_q   <= no_wrap_i;
    end else if (step) begin
      col_q  <= col_next;
    end
  end

  assign col_addr_o = col_q;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int unsigned COL_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             beat_i,
  input logic [COL_W-1:0] col_addr_i,
  input logic [COL_W-1:0] col_addr_o,
  input logic             burst_active_o,
  input logic             burst_done_o,
  input logic             nw_q,
  input logic [COL_W-1:0] wmask
);
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> col_addr_o == $past(col_addr_i));

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!burst_active_o && !start_i) |=> ($stable(col_addr_o) && !burst_done_o));

  p_wrap_upper_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_active_o && !burst_done_o && beat_i && !start_i && !nw_q) |=>
      ((col_addr_o & ~$past(wmask)) == ($past(col_addr_o) & ~$past(wmask))) &&
      ((col_addr_o & $past(wmask)) == (($past(col_addr_o) + COL_W'(1)) & $past(wmask))));

  p_linear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_active_o && !burst_done_o && beat_i && !start_i && nw_q) |=>
      col_addr_o == $past(col_addr_o) + COL_W'(1));

  p_done_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_done_o |-> burst_active_o);

  p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_done_o && !start_i) |=> ($stable(col_addr_o) && burst_done_o));

  p_no_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !beat_i) |=> $stable(col_addr_o));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .beat_i         (beat_i),
  .col_addr_i     (col_addr_i),
  .col_addr_o     (col_addr_o),
  .burst_active_o (burst_active_o),
  .burst_done_o   (burst_done_o),
  .nw_q           (nw_q),
  .wmask          (wmask)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
  localparam int unsigned COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             latch_mode = 1'b1;
  logic             start = 1'b0;
  logic [COL_W-1:0] col_in = '0;
  logic             breq = 1'b0;
  logic [1:0]       blen = 2'd0;
  logic             nw = 1'b0;
  logic             beat = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             active;
  logic             done;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u0 (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .latch_mode_i   (latch_mode),
    .start_i        (start),
    .col_addr_i     (col_in),
    .burst_req_i    (breq),
    .blen_sel_i     (blen),
    .no_wrap_i      (nw),
    .beat_i         (beat),
    .col_addr_o     (col_out),
    .burst_active_o (active),
    .burst_done_o   (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int a, input bit act_e, input bit done_e);
    chk(col_out == COL_W'(a), req, int'(col_out), a);
    chk(active == act_e, req, int'(active), int'(act_e));
    chk(done == done_e, req, int'(done), int'(done_e));
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  function automatic int exp_addr(input int s, input int code, input bit lin, input int k);
    int len = 2 << code;
    if (lin) return (s + k) % (1 << COL_W);
    return (s & ~(len - 1)) | ((s + k) & (len - 1));
  endfunction

  task automatic do_start(input int s, input bit req, input int code, input bit lin);
    @(negedge clk);
    start = 1'b1; col_in = COL_W'(s); breq = req; blen = 2'(code); nw = lin;
    tick();
    @(negedge clk);
    start = 1'b0;
  endtask

  // full burst with one beat per cycle, then one extra beat
  task automatic run_burst(input int s, input int code, input bit lin);
    int len = 2 << code;
    do_start(s, 1'b1, code, lin);
    chk_state("R2", s, 1'b1, 1'b0);
    beat = 1'b1;
    for (int k = 1; k < len; k++) begin
      tick();
      // R5 wrap, R6 linear, R4 length, R7 done timing
      chk_state(lin ? "R6" : "R5", exp_addr(s, code, lin, k), 1'b1, k == len - 1);
    end
    tick();
    chk_state("R8", exp_addr(s, code, lin, len - 1), 1'b1, 1'b1);
    @(negedge clk);
    beat = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #3;
    chk_state("R1", 0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk_state("R1", 0, 1'b0, 1'b0);
    rst_n = 1'b1;
    tick();
    chk_state("R1", 0, 1'b0, 1'b0);

    // R3: no latch configuration
    latch_mode = 1'b0;
    do_start(8'h35, 1'b1, 2, 1'b0);
    chk_state("R2", 8'h35, 1'b0, 1'b0);
    beat = 1'b1;
    repeat (3) begin tick(); chk_state("R3", 8'h35, 1'b0, 1'b0); end
    @(negedge clk); beat = 1'b0;
    latch_mode = 1'b1;

    // R3: no burst request
    do_start(8'hA2, 1'b0, 3, 1'b1);
    chk_state("R3", 8'hA2, 1'b0, 1'b0);
    beat = 1'b1;
    repeat (3) begin tick(); chk_state("R3", 8'hA2, 1'b0, 1'b0); end
    @(negedge clk); beat = 1'b0;

    // R9: beats with idle gaps, 8-beat wrap from 0x5E
    do_start(8'h5E, 1'b1, 2, 1'b0);
    for (int k = 1; k < 8; k++) begin
      @(negedge clk); beat = 1'b0;
      tick();
      chk_state("R9", exp_addr(8'h5E, 2, 1'b0, k - 1), 1'b1, 1'b0);
      @(negedge clk); beat = 1'b1;
      tick();
      chk_state("R9", exp_addr(8'h5E, 2, 1'b0, k), 1'b1, k == 7);
    end
    @(negedge clk); beat = 1'b0;

    // R11: settings changed mid-burst are ignored
    do_start(8'h47, 1'b1, 1, 1'b0);
    blen = 2'd3; nw = 1'b1; beat = 1'b1;
    tick(); chk_state("R11", 8'h44, 1'b1, 1'b0);
    tick(); chk_state("R11", 8'h45, 1'b1, 1'b0);
    tick(); chk_state("R11", 8'h46, 1'b1, 1'b1);
    tick(); chk_state("R11", 8'h46, 1'b1, 1'b1);
    @(negedge clk); beat = 1'b0;

    // R10: start collides with a beat mid-burst
    do_start(8'h10, 1'b1, 1, 1'b0);
    beat = 1'b1;
    tick(); chk_state("R10", 8'h11, 1'b1, 1'b0);
    @(negedge clk);
    start = 1'b1; col_in = 8'h7C; blen = 2'd1; nw = 1'b0;
    tick(); chk_state("R10", 8'h7C, 1'b1, 1'b0);
    @(negedge clk); start = 1'b0;
    tick(); chk_state("R10", 8'h7D, 1'b1, 1'b0);
    tick(); chk_state("R10", 8'h7E, 1'b1, 1'b0);
    tick(); chk_state("R10", 8'h7F, 1'b1, 1'b1);
    @(negedge clk); beat = 1'b0;

    // R4 R5 R6 R7 R8: every start address, every length, both modes
    for (int code = 0; code < 4; code++)
      for (int lin = 0; lin < 2; lin++)
        for (int s = 0; s < (1 << COL_W); s++)
          run_burst(s, code, lin[0]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule